// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-driven SPI master that runs a single flash command per trigger. Software loads a command byte into its own register, sets how many data bytes go out and how many come back, and fills a 64-entry byte buffer with the outgoing data. A write with the start bit set then runs the whole transfer without further help. Chip select goes low. The command byte goes out first, the buffered data bytes follow, and then the engine clocks in the requested number of reply bytes.

The reply bytes land in the same buffer, placed directly after the transmitted data. Software reads them back through the buffer window once a 32-bit status word shows the engine idle. The status word also carries the engine's progress pointers and a flag for requests that do not fit the buffer.

The serial side uses SPI mode 0. The serial clock is the system clock divided by an even parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: After a synchronous active-high reset, all four status bytes read 0, `spi_cs_n` is 1, `spi_sclk` is 0 and the command, transmit-count and receive-count registers read 0.
- R2: Byte registers sit at these addresses: command at 0x00, transmit count at 0x01, receive count at 0x02, start at 0x03, status bytes 0..3 at 0x04..0x07 (least significant byte first), and buffer entry i (0..63) at 0x40+i. When idle, each writable register and buffer entry reads back what was written.
- R3: The first byte shifted out after chip select falls is the command register, MSB first. It is never taken from the buffer.
- R4: After the command byte, buffer entries 0 to tx-1 are shifted out in order, where tx is the transmit count.
- R5: Reply byte k is stored in buffer entry tx+k. The total number of bytes framed by chip select is 1+tx+rx.
- R6: SPI mode 0 is used. SCLK idles low and is always low while chip select is high. Each SCLK high phase lasts CLK_DIV/2 system clocks. MOSI does not change while SCLK is high. MISO is captured on the rising SCLK edge.
- R7: Chip select stays low for the whole transfer. The busy flag (status bit 24) is still 1 in the cycle in which `spi_cs_n` returns high, and it reads 0 one cycle later.
- R8: When a transfer ends, status bits 7:0 (done count) and bits 14:8 (write pointer) both equal tx+rx, and bits 22:16 (read pointer) equal tx.
- R9: A start request with tx+rx greater than 64 sets the error flag (status bit 25). It does not assert chip select and does not set busy. The next legal start clears the flag.
- R10: While busy, writes to any register, to the buffer and to the start register are ignored. Reads, including buffer reads, still return current contents.
- R11: A write to the start register with bit 7 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe, one cycle per byte |
| reg_addr | input | 8 | Register byte address, used for both write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume that the register strobe is driven synchronously and lasts one cycle per access. They also assume that MISO is settled before each rising SCLK edge, and that CLK_DIV is even and at least 2.

The bench meets these conditions as follows. It drives all register inputs on falling system-clock edges. Its flash model changes MISO only when chip select falls or on falling SCLK edges. It also presents the first reply bit of each frame before the first rising edge.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int BUF_DEPTH = 64;
    localparam int BUF_AW    = $clog2(BUF_DEPTH);
    localparam int PTR_W     = BUF_AW + 1;

    localparam logic [7:0] ADR_CMD   = 8'h00;
    localparam logic [7:0] ADR_TXN   = 8'h01;
    localparam logic [7:0] ADR_RXN   = 8'h02;
    localparam logic [7:0] ADR_GO    = 8'h03;
    localparam logic [7:0] ADR_STAT  = 8'h04;
    localparam logic [7:0] ADR_BUF   = 8'h40;
    localparam int         GO_BIT    = 7;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOAD,
        SEQ_SHIFT,
        SEQ_END
    } seq_state_e;

    typedef struct packed {
        logic [5:0]       pad_hi;
        logic             err;
        logic             busy;
        logic             pad_rd;
        logic [PTR_W-1:0] rd_ptr;
        logic             pad_wr;
        logic [PTR_W-1:0] wr_ptr;
        logic [7:0]       done_cnt;
    } status_t;

    function automatic logic [7:0] status_byte(input status_t s, input logic [1:0] k);
        logic [31:0] w;
        w = s;
        return w[int'(k)*8 +: 8];
    endfunction

endpackage

// File: rtl/spi_byte_buf.sv
module spi_byte_buf #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_eng,
    input  logic [AW-1:0] raddr_sw,
    output logic [7:0]    rdata_eng,
    output logic [7:0]    rdata_sw
);
    logic [7:0] ent_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (we && waddr == AW'(i))
                q <= wdata;
        end
        assign ent_q[i] = q;
    end

    assign rdata_eng = ent_q[raddr_eng];
    assign rdata_sw  = ent_q[raddr_sw];

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int HALF = CLK_DIV / 2;
    localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [7:0]      sh_q;
    logic [2:0]      bit_q;
    logic [HC_W-1:0] hc_q;
    logic            act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            bit_q   <= '0;
            hc_q    <= '0;
            act_q   <= 1'b0;
            sclk    <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (start && !act_q) begin
                act_q <= 1'b1;
                sh_q  <= tx_byte;
                hc_q  <= '0;
                bit_q <= '0;
                sclk  <= 1'b0;
            end else if (act_q) begin
                if (hc_q == HC_W'(HALF - 1)) begin
                    hc_q <= '0;
                    if (!sclk) begin
                        sclk    <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bit_q == 3'd7) begin
                            act_q <= 1'b0;
                            done  <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            sh_q  <= {sh_q[6:0], 1'b0};
                        end
                    end
                end else begin
                    hc_q <= hc_q + HC_W'(1);
                end
            end
        end
    end

    assign mosi = sh_q[7];

    a_r6_mosi_steady: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi));
    a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
        !act_q |-> !sclk);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    seq_state_e       state_q;
    logic [7:0]       cmd_q, txn_q, rxn_q, byte_q, done_q;
    logic [PTR_W-1:0] rd_q, wr_q;
    logic             err_q, cs_q;

    logic       busy, sw_wr, buf_win, go_req, legal, eng_wr, sh_done;
    logic [8:0] xfer_sum;
    logic [7:0] eng_rd, sw_rd, rx_byte, tx_byte;
    status_t    stat;

    assign busy     = (state_q != SEQ_IDLE);
    assign sw_wr    = reg_we && !busy;
    assign buf_win  = (reg_addr[7:BUF_AW] == ADR_BUF[7:BUF_AW]);
    assign go_req   = sw_wr && (reg_addr == ADR_GO) && reg_wdata[GO_BIT];
    assign xfer_sum = {1'b0, txn_q} + {1'b0, rxn_q};
    assign legal    = (xfer_sum <= 9'(BUF_DEPTH));
    assign eng_wr   = (state_q == SEQ_SHIFT) && sh_done && (byte_q > txn_q);

    assign tx_byte = (byte_q == 8'd0)  ? cmd_q  :
                     (byte_q <= txn_q) ? eng_rd : 8'h00;

    spi_byte_buf #(.DEPTH(BUF_DEPTH), .AW(BUF_AW)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .we        (busy ? eng_wr : (sw_wr && buf_win)),
        .waddr     (busy ? wr_q[BUF_AW-1:0] : reg_addr[BUF_AW-1:0]),
        .wdata     (busy ? rx_byte : reg_wdata),
        .raddr_eng (rd_q[BUF_AW-1:0]),
        .raddr_sw  (reg_addr[BUF_AW-1:0]),
        .rdata_eng (eng_rd),
        .rdata_sw  (sw_rd)
    );

    spi_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (state_q == SEQ_LOAD),
        .tx_byte (tx_byte),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (sh_done),
        .rx_byte (rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            txn_q <= '0;
            rxn_q <= '0;
        end else if (sw_wr) begin
            case (reg_addr)
                ADR_CMD: cmd_q <= reg_wdata;
                ADR_TXN: txn_q <= reg_wdata;
                ADR_RXN: rxn_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            byte_q  <= '0;
            done_q  <= '0;
            rd_q    <= '0;
            wr_q    <= '0;
            err_q   <= 1'b0;
            cs_q    <= 1'b1;
        end else begin
            case (state_q)
                SEQ_IDLE: if (go_req) begin
                    if (legal) begin
                        state_q <= SEQ_LOAD;
                        cs_q    <= 1'b0;
                        byte_q  <= '0;
                        done_q  <= '0;
                        rd_q    <= '0;
                        wr_q    <= txn_q[PTR_W-1:0];
                        err_q   <= 1'b0;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
                SEQ_LOAD: begin
                    if (byte_q != 8'd0 && byte_q <= txn_q)
                        rd_q <= rd_q + PTR_W'(1);
                    state_q <= SEQ_SHIFT;
                end
                SEQ_SHIFT: if (sh_done) begin
                    if (eng_wr)
                        wr_q <= wr_q + PTR_W'(1);
                    if (byte_q != 8'd0)
                        done_q <= done_q + 8'd1;
                    if ({1'b0, byte_q} == xfer_sum) begin
                        cs_q    <= 1'b1;
                        state_q <= SEQ_END;
                    end else begin
                        byte_q  <= byte_q + 8'd1;
                        state_q <= SEQ_LOAD;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign spi_cs_n = cs_q;

    always_comb begin
        stat          = '0;
        stat.err      = err_q;
        stat.busy     = busy;
        stat.rd_ptr   = rd_q;
        stat.wr_ptr   = wr_q;
        stat.done_cnt = done_q;
    end

    always_comb begin
        if (buf_win)
            reg_rdata = sw_rd;
        else if (reg_addr[7:2] == ADR_STAT[7:2])
            reg_rdata = status_byte(stat, reg_addr[1:0]);
        else begin
            case (reg_addr)
                ADR_CMD: reg_rdata = cmd_q;
                ADR_TXN: reg_rdata = txn_q;
                ADR_RXN: reg_rdata = rxn_q;
                ADR_GO:  reg_rdata = {busy, 7'b0};
                default: reg_rdata = 8'h00;
            endcase
        end
    end

    a_r7_cs_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> spi_cs_n);
    a_r7_busy_release: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |=> !busy);
    a_r6_sclk_framed: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);
    a_r9_oversize_blocked: assert property (@(posedge clk) disable iff (rst)
        (!busy && go_req && !legal) |=> (!busy && err_q && spi_cs_n));
    a_r5_wr_bound: assert property (@(posedge clk) disable iff (rst)
        wr_q <= PTR_W'(BUF_DEPTH));
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_we) |=> ($stable(cmd_q) && $stable(txn_q) && $stable(rxn_q)));

endmodule

// File: tb/spi_cmd_engine_test.sv
`timescale 1ns/1ps
module spi_cmd_engine_test;

    localparam int DIV = 4;
    localparam int NV  = 6;
    // {command, tx count, rx count}
    localparam logic [23:0] VEC [NV] = '{
        24'h9F_00_03, 24'h03_03_04, 24'h02_04_00,
        24'h0B_00_00, 24'h03_04_3C, 24'h05_40_00
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       spi_cs_n, spi_sclk, spi_mosi;
    logic       spi_miso = 1'b0;

    int total = 0;
    int bad   = 0;

    spi_cmd_engine #(.CLK_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] resp(input int j);
        return 8'hC3 ^ 8'(j * 29);
    endfunction

    function automatic logic [7:0] tx_pat(input logic [7:0] op, input int i);
        return op + 8'(7 * i + 1);
    endfunction

    // flash model
    logic [7:0] cap [80];
    int sbit = 0, sbyte = 0, cs_falls = 0;
    always @(negedge spi_cs_n) begin
        sbit = 0; sbyte = 0; cs_falls++;
        spi_miso = resp(0)[7];
    end
    always @(posedge spi_sclk) if (!spi_cs_n && sbyte < 80) begin
        cap[sbyte] = {cap[sbyte][6:0], spi_mosi};
        sbit++;
        if (sbit == 8) begin sbit = 0; sbyte++; end
    end
    always @(negedge spi_sclk) if (!spi_cs_n)
        spi_miso = resp(sbyte)[7 - sbit];

    // SCLK high-phase width monitor
    int hi_run = 0, width_bad = 0, width_seen = 0;
    always @(negedge clk) begin
        if (spi_sclk) hi_run++;
        else if (hi_run != 0) begin
            width_seen++;
            if (hi_run != DIV / 2) width_bad++;
            hi_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_stat(output logic [31:0] s);
        logic [7:0] b;
        for (int k = 0; k < 4; k++) begin
            rd(8'h04 + 8'(k), b);
            s[k*8 +: 8] = b;
        end
    endtask

    task automatic wait_idle();
        logic prev_cs;
        prev_cs = spi_cs_n;
        reg_addr = 8'h07;
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            #1;
            if (!prev_cs && spi_cs_n) begin
                chk(reg_rdata[0] == 1'b1, "R7 busy held at cs release", int'(reg_rdata[0]), 1);
                @(negedge clk);
                #1;
                chk(reg_rdata[0] == 1'b0, "R7 busy clear one cycle later", int'(reg_rdata[0]), 0);
                return;
            end
            prev_cs = spi_cs_n;
        end
        chk(1'b0, "R7 transfer did not end", 0, 1);
    endtask

    task automatic run_cmd(input logic [7:0] op, input int tx, input int rx);
        logic [7:0]  d;
        logic [31:0] s;
        int          mism;
        wr(8'h00, op);
        wr(8'h01, 8'(tx));
        wr(8'h02, 8'(rx));
        for (int i = 0; i < tx; i++) wr(8'h40 + 8'(i), tx_pat(op, i));
        wr(8'h03, 8'h80);
        wait_idle();
        chk(sbyte == 1 + tx + rx, "R5 framed byte count", sbyte, 1 + tx + rx);
        chk(cap[0] == op, "R3 command byte first", int'(cap[0]), int'(op));
        mism = 0;
        for (int i = 0; i < tx; i++) if (cap[1 + i] != tx_pat(op, i)) mism++;
        chk(mism == 0, "R4 transmit bytes in order", mism, 0);
        mism = 0;
        for (int k = 0; k < rx; k++) begin
            rd(8'h40 + 8'(tx + k), d);
            if (d != resp(1 + tx + k)) mism++;
        end
        chk(mism == 0, "R5 reply bytes after transmit bytes", mism, 0);
        rd_stat(s);
        chk(s[7:0] == 8'(tx + rx), "R8 done count", int'(s[7:0]), tx + rx);
        chk(s[14:8] == 7'(tx + rx), "R8 write pointer", int'(s[14:8]), tx + rx);
        chk(s[22:16] == 7'(tx), "R8 read pointer", int'(s[22:16]), tx);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [31:0] s;
        int          f0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_stat(s);
        chk(s == 32'h0, "R1 status after reset", int'(s), 0);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 pins after reset",
            int'({spi_cs_n, spi_sclk}), 2);
        rd(8'h01, d);
        chk(d == 8'h00, "R1 count after reset", int'(d), 0);

        // R2 register map readback
        wr(8'h00, 8'hA5);
        rd(8'h00, d);
        chk(d == 8'hA5, "R2 command readback", int'(d), 'hA5);
        wr(8'h7F, 8'h3C);
        rd(8'h7F, d);
        chk(d == 8'h3C, "R2 last buffer entry readback", int'(d), 'h3C);
        wr(8'h02, 8'h11);
        rd(8'h02, d);
        chk(d == 8'h11, "R2 receive count readback", int'(d), 'h11);

        // table of transfers: R3 R4 R5 R7 R8
        for (int v = 0; v < NV; v++)
            run_cmd(VEC[v][23:16], int'(VEC[v][15:8]), int'(VEC[v][7:0]));

        // R6 SCLK timing
        chk(width_bad == 0 && width_seen > 0, "R6 sclk high width", width_bad, 0);

        // R9 oversize request
        f0 = cs_falls;
        wr(8'h01, 8'd40);
        wr(8'h02, 8'd30);
        wr(8'h03, 8'h80);
        repeat (4) @(negedge clk);
        rd_stat(s);
        chk(cs_falls == f0, "R9 no chip select on oversize", cs_falls, f0);
        chk(s[25:24] == 2'b10, "R9 error set busy clear", int'(s[25:24]), 2);
        run_cmd(8'h05, 0, 1);
        rd_stat(s);
        chk(s[25] == 1'b0, "R9 error cleared by legal start", int'(s[25]), 0);

        // R11 start bit clear
        f0 = cs_falls;
        wr(8'h03, 8'h7F);
        repeat (4) @(negedge clk);
        rd(8'h07, d);
        chk(cs_falls == f0 && d[0] == 1'b0, "R11 no start without bit 7", cs_falls, f0);

        // R10 writes ignored while busy
        wr(8'h00, 8'h3B);
        wr(8'h01, 8'd2);
        wr(8'h02, 8'd8);
        wr(8'h40, 8'hE1);
        wr(8'h41, 8'hE2);
        f0 = cs_falls;
        wr(8'h03, 8'h80);
        wr(8'h00, 8'h77);
        wr(8'h01, 8'd5);
        wr(8'h40, 8'h00);
        wr(8'h03, 8'h80);
        rd(8'h41, d);
        chk(d == 8'hE2, "R10 buffer read while busy", int'(d), 'hE2);
        wait_idle();
        rd(8'h00, d);
        chk(d == 8'h3B, "R10 command write ignored", int'(d), 'h3B);
        rd(8'h01, d);
        chk(d == 8'd2, "R10 count write ignored", int'(d), 2);
        rd(8'h40, d);
        chk(d == 8'hE1, "R10 buffer write ignored", int'(d), 'hE1);
        chk(cap[0] == 8'h3B && cs_falls == f0 + 1, "R10 single frame with original command",
            int'(cap[0]), 'h3B);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule